// File: doc/BRIEF.md
# Modulated Pulse Width Monitor

This block supervises the active pulses of one modulated output channel. It samples the level of the channel's output (`pulse_in`) once per clock. A hold-off counter measures how many consecutive samples each pulse stays high. Two faults are detected:

- A pulse that drops before the minimum width has been reached is a **short** pulse.
- A pulse that is still high once the minimum width plus the range allowance has elapsed is an **open** pulse.

Each fault sets a sticky flag. Software clears a flag by pulsing the matching clear input.

Checking only applies to pulses that the modulation request still asks for.

- A pulse ended on purpose is never reported as short. A pulse ends on purpose when the channel is disabled, or when both the external timing signal and the software modulation bit are low.
- While a sequencer claims the shared hold-off counter (`seq_borrow`), checking is suspended and nothing is flagged.
- Checking picks up again from the first pulse that starts after the claim ends.

A separate input, `force_short`, lets the channel-off logic record a short pulse directly.

Top module: `pwm_width_monitor`

## Requirements
- R1: After a synchronous reset both `short_flag` and `open_flag` read 0.
- R2: When checking is active, a pulse sampled high for W consecutive clock edges with W less than `min_width` sets `short_flag`. The flag is set on the edge that first samples `pulse_in` low. For this, the modulation request (`chan_en` high and `ext_mod` or `sw_mod` high) must still be present at that edge.
- R3: A pulse sampled high for at least `min_width` edges and at most `min_width + range_width` edges sets neither flag.
- R4: When checking is active, `open_flag` is set on the edge that samples a pulse high for the (`min_width + range_width` + 1)-th consecutive time. With exactly `min_width + range_width` high samples, the flag stays 0.
- R5: When `min_width` is 0 or `range_width` is 0, no width check is made and neither flag is set by pulse activity.
- R6: A pulse whose falling sample coincides with `chan_en` low, or with both `ext_mod` and `sw_mod` low, does not set `short_flag`, however short it was.
- R7: `open_flag` is never set while the modulation request is absent, even when `pulse_in` is held high beyond the limit.
- R8: While `seq_borrow` is high, neither flag is set by pulse activity and no conflict is signalled. A pulse that is in progress when `seq_borrow` falls is not checked.
- R9: The first pulse that rises while `seq_borrow` is low after a borrow period is checked normally.
- R10: `force_short` high on an edge sets `short_flag`, whatever the configuration and borrow state.
- R11: Both flags are sticky. A 1 on `clr_short` or `clr_open` clears the matching flag on the next edge. If a clear and a new detection of the same flag fall on the same edge, the flag is set.
- R12: The hold-off counter is 8 bits wide and saturates at 255. When `min_width + range_width` exceeds 255, the open check never fires, however long the pulse lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| ext_mod | input | 1 | External timing modulation source |
| sw_mod | input | 1 | Software modulation bit |
| pulse_in | input | 1 | Level of the monitored modulated output |
| min_width | input | 8 | Minimum pulse width in clock samples |
| range_width | input | 8 | Extra samples allowed beyond the minimum |
| seq_borrow | input | 1 | Sequencer has claimed the hold-off counter |
| force_short | input | 1 | Channel-off narrow pulse: set the short flag |
| clr_short | input | 1 | Write-one clear of the short flag |
| clr_open | input | 1 | Write-one clear of the open flag |
| short_flag | output | 1 | Sticky short-pulse flag |
| open_flag | output | 1 | Sticky open (too long) flag |

## Verification
The short check is exercised in three ways, to separate "dropped too early" from "ended on purpose":

- pulses below, at and above the minimum width;
- a short pulse whose falling sample coincides with the modulation sources dropping;
- a short pulse whose falling sample coincides with the channel being disabled.

The open check is probed at exactly the limit and one sample past it. This pins down the off-by-one edge. It is then repeated with the modulation request removed and with a limit above the counter's reach.

Two borrow patterns are applied:

- a pulse held entirely inside the borrow window;
- a pulse straddling the end of the window, followed by a fresh short pulse.

Together these show that checking is suspended and then resumes. Clears are driven both alone and on the same edge as a set, which exposes which of the two has priority.

// File: rtl/pwm_mon_pkg.sv
package pwm_mon_pkg;
  localparam int CNT_W = 8;
  localparam int NUM_FLAGS = 2;
  typedef enum logic [0:0] {
    FLAG_SHORT = 1'b0,
    FLAG_OPEN  = 1'b1
  } flag_idx_e;
endpackage

// File: rtl/pwm_mon_edge.sv
module pwm_mon_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise,
  output logic fall,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
  assign fall = ~level_in & level_q;
endmodule

// File: rtl/pwm_mon_holdoff.sv
module pwm_mon_holdoff #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level_in,
  input  logic             rise,
  input  logic             borrow,
  output logic [CNT_W-1:0] count,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_nxt;
  logic             armed_nxt;

  always_comb begin
    count_nxt = count;
    if (borrow || !level_in)  count_nxt = '0;
    else if (rise)            count_nxt = CNT_ONE;
    else if (count != CNT_MAX) count_nxt = count + CNT_ONE;
  end

  always_comb begin
    armed_nxt = armed;
    if (borrow)         armed_nxt = 1'b0;
    else if (rise)      armed_nxt = 1'b1;
    else if (!level_in) armed_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      armed <= 1'b0;
    end else begin
      count <= count_nxt;
      armed <= armed_nxt;
    end
  end
endmodule

// File: rtl/pwm_mon_judge.sv
module pwm_mon_judge #(
  parameter int CNT_W = 8
) (
  input  logic             level_in,
  input  logic             level_q,
  input  logic             fall,
  input  logic             armed,
  input  logic             borrow,
  input  logic             mod_req,
  input  logic             force_short,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] min_width,
  input  logic [CNT_W-1:0] range_width,
  output logic             short_set,
  output logic             open_set
);
  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] limit;
  logic             cfg_ok;
  logic             check_on;

  assign limit    = {1'b0, min_width} + {1'b0, range_width};
  assign cfg_ok   = (min_width != '0) && (range_width != '0);
  assign check_on = cfg_ok && armed && !borrow && mod_req;

  assign short_set = force_short || (check_on && fall && (count < min_width));
  assign open_set  = check_on && level_in && level_q && ({1'b0, count} >= limit);
endmodule

// File: rtl/pwm_mon_flag.sv
module pwm_mon_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/pwm_width_monitor.sv
module pwm_width_monitor
  import pwm_mon_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             ext_mod,
  input  logic             sw_mod,
  input  logic             pulse_in,
  input  logic [WIDTH-1:0] min_width,
  input  logic [WIDTH-1:0] range_width,
  input  logic             seq_borrow,
  input  logic             force_short,
  input  logic             clr_short,
  input  logic             clr_open,
  output logic             short_flag,
  output logic             open_flag
);
  logic             rise, fall, level_q;
  logic [WIDTH-1:0] count;
  logic             armed;
  logic             mod_req;
  logic             short_set, open_set;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_vec;

  assign mod_req = chan_en && (ext_mod || sw_mod);

  pwm_mon_edge u_edge (
    .clk(clk), .rst(rst), .level_in(pulse_in),
    .rise(rise), .fall(fall), .level_q(level_q)
  );

  pwm_mon_holdoff #(.CNT_W(WIDTH)) u_holdoff (
    .clk(clk), .rst(rst), .level_in(pulse_in), .rise(rise),
    .borrow(seq_borrow), .count(count), .armed(armed)
  );

  pwm_mon_judge #(.CNT_W(WIDTH)) u_judge (
    .level_in(pulse_in), .level_q(level_q), .fall(fall), .armed(armed),
    .borrow(seq_borrow), .mod_req(mod_req), .force_short(force_short),
    .count(count), .min_width(min_width), .range_width(range_width),
    .short_set(short_set), .open_set(open_set)
  );

  assign set_vec[FLAG_SHORT] = short_set;
  assign set_vec[FLAG_OPEN]  = open_set;
  assign clr_vec[FLAG_SHORT] = clr_short;
  assign clr_vec[FLAG_OPEN]  = clr_open;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pwm_mon_flag u_flag (
      .clk(clk), .rst(rst), .set(set_vec[g]), .clr(clr_vec[g]),
      .flag(flag_vec[g])
    );
  end

  assign short_flag = flag_vec[FLAG_SHORT];
  assign open_flag  = flag_vec[FLAG_OPEN];
endmodule

// File: rtl/pwm_width_monitor_chk.sv
module pwm_width_monitor_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             ext_mod,
  input logic             sw_mod,
  input logic             pulse_in,
  input logic [WIDTH-1:0] min_width,
  input logic [WIDTH-1:0] range_width,
  input logic             seq_borrow,
  input logic             force_short,
  input logic             clr_short,
  input logic             clr_open,
  input logic             short_flag,
  input logic             open_flag
);
  logic mod_req;
  assign mod_req = chan_en && (ext_mod || sw_mod);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!short_flag && !open_flag));

  a_r11_short_sticky: assert property (@(posedge clk) disable iff (rst)
    (short_flag && !clr_short) |=> short_flag);

  a_r11_open_sticky: assert property (@(posedge clk) disable iff (rst)
    (open_flag && !clr_open) |=> open_flag);

  a_r11_open_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_open && !pulse_in) |=> !open_flag);

  a_r7_open_needs_req: assert property (@(posedge clk) disable iff (rst)
    (!open_flag && !mod_req) |=> !open_flag);

  a_r6_no_short_on_purpose: assert property (@(posedge clk) disable iff (rst)
    (!short_flag && !force_short && !mod_req) |=> !short_flag);

  a_r8_borrow_no_short: assert property (@(posedge clk) disable iff (rst)
    (!short_flag && !force_short && seq_borrow) |=> !short_flag);

  a_r8_borrow_no_open: assert property (@(posedge clk) disable iff (rst)
    (!open_flag && seq_borrow) |=> !open_flag);

  a_r5_zero_cfg_no_open: assert property (@(posedge clk) disable iff (rst)
    (!open_flag && (min_width == '0 || range_width == '0)) |=> !open_flag);

  a_r10_force_sets: assert property (@(posedge clk) disable iff (rst)
    force_short |=> short_flag);
endmodule

bind pwm_width_monitor pwm_width_monitor_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_pwm_width_monitor.sv
module test_pwm_width_monitor;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst;
  logic chan_en, ext_mod, sw_mod, pulse_in;
  logic [7:0] min_width, range_width;
  logic seq_borrow, force_short, clr_short, clr_open;
  logic short_flag, open_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_width_monitor i_pwm_width_monitor (
    .clk(clk), .rst(rst), .chan_en(chan_en), .ext_mod(ext_mod),
    .sw_mod(sw_mod), .pulse_in(pulse_in), .min_width(min_width),
    .range_width(range_width), .seq_borrow(seq_borrow),
    .force_short(force_short), .clr_short(clr_short), .clr_open(clr_open),
    .short_flag(short_flag), .open_flag(open_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic defaults();
    chan_en = 1'b1; ext_mod = 1'b0; sw_mod = 1'b1; pulse_in = 1'b0;
    min_width = 8'd3; range_width = 8'd4; seq_borrow = 1'b0;
    force_short = 1'b0; clr_short = 1'b0; clr_open = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    pulse_in = 1'b0; clr_short = 1'b1; clr_open = 1'b1;
    @(negedge clk);
    clr_short = 1'b0; clr_open = 1'b0;
    @(negedge clk);
  endtask

  // high for n sampling edges, then low; returns at negedge after fall sample
  task automatic pulse(input int n);
    pulse_in = 1'b1;
    repeat (n) @(negedge clk);
    pulse_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 short after reset", short_flag, 1'b0);
    chk("R1 open after reset", open_flag, 1'b0);
  endtask

  task automatic t_short();
    clear_all();
    pulse(2);
    chk("R2 short pulse of 2 under min 3", short_flag, 1'b1);
    clear_all(); ext_mod = 1'b1; sw_mod = 1'b0;
    pulse(1);
    chk("R2 short pulse via external source", short_flag, 1'b1);
    sw_mod = 1'b1; ext_mod = 1'b0;
  endtask

  task automatic t_normal();
    clear_all();
    pulse(3);
    chk("R3 width equal min", short_flag, 1'b0);
    pulse(7);
    chk("R3 width equal limit short", short_flag, 1'b0);
    chk("R3 width equal limit open", open_flag, 1'b0);
  endtask

  task automatic t_open();
    clear_all();
    pulse_in = 1'b1;
    repeat (7) @(negedge clk);
    chk("R4 open not yet at limit", open_flag, 1'b0);
    @(negedge clk);
    chk("R4 open one past limit", open_flag, 1'b1);
    pulse_in = 1'b0; @(negedge clk);
    chk("R4 long pulse not short", short_flag, 1'b0);
  endtask

  task automatic t_zero_cfg();
    clear_all(); min_width = 8'd0;
    pulse(1); pulse(20);
    chk("R5 min zero no short", short_flag, 1'b0);
    chk("R5 min zero no open", open_flag, 1'b0);
    min_width = 8'd3; range_width = 8'd0;
    pulse(1); pulse(20);
    chk("R5 range zero no short", short_flag, 1'b0);
    chk("R5 range zero no open", open_flag, 1'b0);
    range_width = 8'd4;
  endtask

  task automatic t_intentional();
    clear_all();
    pulse_in = 1'b1; @(negedge clk);
    pulse_in = 1'b0; sw_mod = 1'b0; @(negedge clk);
    chk("R6 modulation dropped no short", short_flag, 1'b0);
    sw_mod = 1'b1; @(negedge clk);
    pulse_in = 1'b1; @(negedge clk);
    pulse_in = 1'b0; chan_en = 1'b0; @(negedge clk);
    chk("R6 channel disabled no short", short_flag, 1'b0);
    chan_en = 1'b1;
  endtask

  task automatic t_open_needs_req();
    clear_all(); sw_mod = 1'b0;
    pulse(20);
    chk("R7 no open without modulation", open_flag, 1'b0);
    sw_mod = 1'b1; chan_en = 1'b0;
    pulse(20);
    chk("R7 no open with channel off", open_flag, 1'b0);
    chan_en = 1'b1;
  endtask

  task automatic t_borrow();
    clear_all(); seq_borrow = 1'b1;
    pulse(1); pulse(20);
    chk("R8 borrow no short", short_flag, 1'b0);
    chk("R8 borrow no open", open_flag, 1'b0);
    pulse_in = 1'b1; @(negedge clk);
    seq_borrow = 1'b0; @(negedge clk);
    pulse_in = 1'b0; @(negedge clk);
    chk("R8 straddling pulse unchecked", short_flag, 1'b0);
  endtask

  task automatic t_resume();
    clear_all();
    pulse(2);
    chk("R9 short detected after borrow", short_flag, 1'b1);
    clear_all();
    pulse(8);
    chk("R9 open detected after borrow", open_flag, 1'b1);
  endtask

  task automatic t_force();
    clear_all(); seq_borrow = 1'b1; min_width = 8'd0;
    force_short = 1'b1; @(negedge clk);
    force_short = 1'b0; seq_borrow = 1'b0; min_width = 8'd3;
    chk("R10 forced short", short_flag, 1'b1);
    chk("R10 forced short leaves open", open_flag, 1'b0);
  endtask

  task automatic t_clear();
    clear_all();
    force_short = 1'b1; @(negedge clk); force_short = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 short stays set", short_flag, 1'b1);
    clr_short = 1'b1; @(negedge clk); clr_short = 1'b0;
    chk("R11 short cleared", short_flag, 1'b0);
    force_short = 1'b1; clr_short = 1'b1; @(negedge clk);
    force_short = 1'b0; clr_short = 1'b0;
    chk("R11 set wins over clear", short_flag, 1'b1);
    clear_all();
    pulse_in = 1'b1; repeat (7) @(negedge clk);
    clr_open = 1'b1; @(negedge clk); clr_open = 1'b0;
    chk("R11 open set wins over clear", open_flag, 1'b1);
    pulse_in = 1'b0; @(negedge clk);
    clr_open = 1'b1; @(negedge clk); clr_open = 1'b0;
    chk("R11 open cleared", open_flag, 1'b0);
  endtask

  task automatic t_saturate();
    clear_all(); min_width = 8'd200; range_width = 8'd100;
    pulse(300);
    chk("R12 limit beyond counter no open", open_flag, 1'b0);
    chk("R12 long pulse not short", short_flag, 1'b0);
    min_width = 8'd200; range_width = 8'd55;
    pulse_in = 1'b1; repeat (255) @(negedge clk);
    chk("R12 limit 255 not yet open", open_flag, 1'b0);
    @(negedge clk);
    chk("R12 limit 255 open at 256", open_flag, 1'b1);
    pulse_in = 1'b0; @(negedge clk);
    min_width = 8'd3; range_width = 8'd4;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_short();
    t_normal();
    t_open();
    t_zero_cfg();
    t_intentional();
    t_open_needs_req();
    t_borrow();
    t_resume();
    t_force();
    t_clear();
    t_saturate();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule